// File: doc/BRIEF.md
# Power-On Strap Capture and Pin Turnaround

This block sits between a handful of shared package pins and the clock tree of a clock-generator die. While power-on reset is held, the pins act as inputs. Their levels are treated as configuration straps. On the first clock edge after reset releases, the block latches those levels into a small configuration word. On the same edge it turns every shared pin into an output that carries its assigned internal clock.

A pin that nothing drives reads as its pull value. The pad reports whether the level it sees is driven through a per-pin flag. Two bits of the latched word form a CPU frequency-select code. The block decodes this code into one-hot selects for the CPU divider and the PCI divider. A third bit says whether the free-running CPU and SDRAM clocks can be halted by the clock-stop request. The remaining latched bits are spare and appear only in the configuration word. Once latched, the word cannot change until power-on reset asserts again.

Top module: `strap_turnaround`

## Requirements
- R1: While `por_n` is low, every bit of `pin_oe` is 0, every bit of `pin_out` is 0, and `cfg_word` holds the pull pattern.
- R2: `pin_oe` stays all 0 between the release of `por_n` and the next rising clock edge. It becomes all 1 on that edge.
- R3: On that edge, `cfg_word[i]` takes the level of `pin_in[i]` if `pin_driven[i]` is 1. Otherwise it takes the pull value of bit i.
- R4: After the capture edge, `cfg_word` ignores every later change on `pin_in` and `pin_driven` until `por_n` goes low again.
- R5: The pull pattern is 1 for bit 0 (the low select bit), 0 for bit 1 (the high select bit), 1 for bit 2 (the stop-enable bit), and 1 for spare bits 3 and 4.
- R6: `cpu_sel` is one-hot with bit k set, where k = {cfg_word[1], cfg_word[0]}. Code 0 selects 66.66 MHz, 1 selects 100.00 MHz, 2 selects 97.00 MHz and 3 selects 133.33 MHz.
- R7: `pci_sel` is 2'b10 (32.33 MHz) when the code is 2. For every other code it is 2'b01 (33.33 MHz).
- R8: `clk_stoppable` equals `cfg_word[2]`. A value of 1 means the free-running outputs obey the clock-stop request. A value of 0 means they keep running.
- R9: After the capture edge, `pin_out` equals `clk_src` bit for bit.
- R10: Asserting `por_n` low drops `pin_oe` to all 0 at once, without waiting for a clock edge. The next release captures the pins afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| pin_in | input | 5 | Levels seen at the shared pads |
| pin_driven | input | 5 | Per pad, 1 when the level is externally driven |
| clk_src | input | 5 | Clock each pin carries after turnaround |
| pin_oe | output | 5 | Pad output enables |
| pin_out | output | 5 | Pad output data |
| cfg_word | output | 5 | Latched strap word |
| cpu_sel | output | 4 | One-hot CPU divider select |
| pci_sel | output | 2 | One-hot PCI divider select |
| clk_stoppable | output | 1 | Free-running outputs may be halted |

## Verification
The bench builds the block with its default parameters: five pins, select bits at positions 0 and 1, the stop-enable bit at position 2, and the pull pattern 5'b11101. This width is small enough to sweep all 32 pin levels against all 32 driven masks. The sweep reaches every frequency code and both stop-enable values, and it exercises every mix of driven and pulled pins. Each release is followed by inverted pins to test the freeze, by a fresh clock pattern to test the pass-through, and by a reassertion of reset.

// File: rtl/strap_pkg.sv
package strap_pkg;

    // CPU rate selected by the two frequency strap bits
    typedef enum logic [1:0] {
        RATE_66  = 2'b00,
        RATE_100 = 2'b01,
        RATE_97  = 2'b10,
        RATE_133 = 2'b11
    } cpu_rate_e;

    localparam int CPU_CHOICES = 4;
    localparam int PCI_CHOICES = 2;

endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int              N    = 5,
    parameter logic [N-1:0]    PULL = 5'b11101
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [N-1:0] pin_in,
    input  logic [N-1:0] pin_driven,
    output logic         turned_o,
    output logic [N-1:0] cfg_o
);

    typedef struct packed {
        logic         turned;
        logic [N-1:0] cfg;
    } cap_t;

    cap_t st_d, st_q;
    logic [N-1:0] resolved;

    always_comb begin
        resolved = (pin_in & pin_driven) | (PULL & ~pin_driven);
        st_d     = st_q;
        if (!st_q.turned) begin
            st_d.turned = 1'b1;
            st_d.cfg    = resolved;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.turned <= 1'b0;
            st_q.cfg    <= PULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign turned_o = st_q.turned;
    assign cfg_o    = st_q.cfg;

    // R4: once captured, the word never moves while reset stays released
    a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!por_n)
        st_q.turned |=> $stable(st_q.cfg));

    // R2: the turnaround happens on the first edge after release and sticks
    a_r2_turn_once: assert property (@(posedge clk) disable iff (!por_n)
        !st_q.turned |=> st_q.turned);

endmodule

// File: rtl/pad_turn.sv
module pad_turn #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         oe_i,
    input  logic [N-1:0] clk_src,
    output logic [N-1:0] pin_oe,
    output logic [N-1:0] pin_out
);

    for (genvar i = 0; i < N; i++) begin : g_pad
        assign pin_oe[i]  = oe_i;
        assign pin_out[i] = oe_i & clk_src[i];
    end

    // R1: a pad that is not enabled never presents a high level
    a_r1_quiet_pad: assert property (@(negedge clk)
        !pin_oe[0] |-> (pin_out == '0));

endmodule

// File: rtl/freq_decode.sv
module freq_decode
    import strap_pkg::*;
(
    input  logic                   clk,
    input  logic [1:0]             fs,
    output logic [CPU_CHOICES-1:0] cpu_sel,
    output logic [PCI_CHOICES-1:0] pci_sel
);

    cpu_rate_e rate;

    always_comb begin
        rate = cpu_rate_e'(fs);
    end

    for (genvar k = 0; k < CPU_CHOICES; k++) begin : g_cpu
        assign cpu_sel[k] = (fs == k[1:0]);
    end

    always_comb begin
        case (rate)
            RATE_97: pci_sel = 2'b10;
            default: pci_sel = 2'b01;
        endcase
    end

    // R6: exactly one CPU divider choice at any time
    a_r6_cpu_onehot: assert property (@(negedge clk)
        $countones(cpu_sel) == 1);

    // R7: exactly one PCI divider choice at any time
    a_r7_pci_onehot: assert property (@(negedge clk)
        $countones(pci_sel) == 1);

endmodule

// File: rtl/strap_turnaround.sv
module strap_turnaround
    import strap_pkg::*;
#(
    parameter int           NPINS    = 5,
    parameter int           FS0_POS  = 0,
    parameter int           FS1_POS  = 1,
    parameter int           STOP_POS = 2,
    parameter logic [NPINS-1:0] PULL = 5'b11101
) (
    input  logic                   clk,
    input  logic                   por_n,
    input  logic [NPINS-1:0]       pin_in,
    input  logic [NPINS-1:0]       pin_driven,
    input  logic [NPINS-1:0]       clk_src,
    output logic [NPINS-1:0]       pin_oe,
    output logic [NPINS-1:0]       pin_out,
    output logic [NPINS-1:0]       cfg_word,
    output logic [CPU_CHOICES-1:0] cpu_sel,
    output logic [PCI_CHOICES-1:0] pci_sel,
    output logic                   clk_stoppable
);

    logic       turned;
    logic [1:0] fs_code;

    strap_capture #(.N(NPINS), .PULL(PULL)) u_cap (
        .clk        (clk),
        .por_n      (por_n),
        .pin_in     (pin_in),
        .pin_driven (pin_driven),
        .turned_o   (turned),
        .cfg_o      (cfg_word)
    );

    pad_turn #(.N(NPINS)) u_pad (
        .clk     (clk),
        .oe_i    (turned),
        .clk_src (clk_src),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    assign fs_code       = {cfg_word[FS1_POS], cfg_word[FS0_POS]};
    assign clk_stoppable = cfg_word[STOP_POS];

    freq_decode u_dec (
        .clk     (clk),
        .fs      (fs_code),
        .cpu_sel (cpu_sel),
        .pci_sel (pci_sel)
    );

    // R10: pads are released whenever reset is held
    a_r10_oe_off_in_reset: assert property (@(negedge clk)
        !por_n |-> (pin_oe == '0));

    // R1: the word shows the pull pattern while reset is held
    a_r1_pull_in_reset: assert property (@(negedge clk)
        !por_n |-> (cfg_word == PULL));

endmodule

// File: tb/strap_turnaround_test.sv
module strap_turnaround_test;

    logic       clk = 1'b0;
    logic       por_n = 1'b1;
    logic [4:0] pin_in = '0;
    logic [4:0] pin_driven = '0;
    logic [4:0] clk_src = '0;
    logic [4:0] pin_oe, pin_out, cfg_word;
    logic [3:0] cpu_sel;
    logic [1:0] pci_sel;
    logic       clk_stoppable;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [4:0] PULL_EXP = 5'b11101; // R5

    always #5 clk = ~clk;

    strap_turnaround uut (
        .clk(clk), .por_n(por_n), .pin_in(pin_in), .pin_driven(pin_driven),
        .clk_src(clk_src), .pin_oe(pin_oe), .pin_out(pin_out),
        .cfg_word(cfg_word), .cpu_sel(cpu_sel), .pci_sel(pci_sel),
        .clk_stoppable(clk_stoppable)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #1 por_n = 1'b0;
        for (int pat = 0; pat < 32; pat++) begin
            for (int msk = 0; msk < 32; msk++) begin
                logic [4:0] res;
                logic [1:0] code;
                logic [4:0] src;
                res  = (5'(pat) & 5'(msk)) | (PULL_EXP & ~5'(msk));
                code = res[1:0];
                src  = 5'((pat * 7 + msk * 3 + 1) % 32);

                @(negedge clk);
                por_n      = 1'b0;
                pin_in     = 5'(pat);
                pin_driven = 5'(msk);
                clk_src    = 5'b11111;
                #1;
                chk(pin_oe == 5'b0, "R10", int'(pin_oe), 0);
                chk(pin_out == 5'b0, "R1", int'(pin_out), 0);
                chk(cfg_word == PULL_EXP, "R5", int'(cfg_word), int'(PULL_EXP));

                @(negedge clk);
                por_n = 1'b1;
                #1;
                chk(pin_oe == 5'b0, "R2", int'(pin_oe), 0);

                @(negedge clk);
                chk(pin_oe == 5'b11111, "R2", int'(pin_oe), 31);
                chk(cfg_word == res, "R3", int'(cfg_word), int'(res));
                chk(cpu_sel == 4'(1 << code), "R6", int'(cpu_sel), 1 << code);
                chk(pci_sel == ((code == 2'd2) ? 2'b10 : 2'b01), "R7",
                    int'(pci_sel), (code == 2'd2) ? 2 : 1);
                chk(clk_stoppable == res[2], "R8", int'(clk_stoppable), int'(res[2]));

                pin_in     = ~5'(pat);
                pin_driven = ~5'(msk);
                clk_src    = src;
                @(negedge clk);
                chk(cfg_word == res, "R4", int'(cfg_word), int'(res));
                chk(pin_out == src, "R9", int'(pin_out), int'(src));
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule